// File: doc/BRIEF.md
# Infrared port FIFO status and interrupt register

This block is the status register of a serial infrared transceiver. It holds six status bits. Three of them are sticky event bits: hardware sets them from one-cycle pulses, and software clears them by writing a 1. The other three are read-only flags that follow live hardware conditions: transmit FIFO occupancy at or below a threshold, receive FIFO trigger reached, and a receive-side end/error indication. Each flag is sampled into a register.

The two service flags drive the transmit and receive DMA requests directly. They reach the single interrupt line only when their own interrupt enable is set. The interrupt line is a register. It is the OR of all set sources after masking, and it moves in the same cycle as the status bits it reflects. The FIFOs, the line framing logic and the DMA engine sit outside this block.

Top module: `irda_fifo_status`

## Requirements
- R1: After reset, rd_data, dma_tx_req, dma_rx_req and irq are all 0.
- R2: rd_data[31:6] always reads 0. Only bits 5:0 carry status, and a write cannot change the upper bits.
- R3: A pulse on frame_err_pulse, rx_abort_pulse or tx_underrun_pulse sets rd_data bit 5, bit 2 or bit 1 respectively at the next clock edge. The bit then holds until it is cleared.
- R4: On a cycle with wr_en high, a 1 in wr_data bit 5, 2 or 1 clears that sticky bit at the next edge. A 0 in the same position leaves the bit unchanged.
- R5: When a set pulse and a write-1 clear reach the same sticky bit in the same cycle, the bit is 1 after the edge.
- R6: rd_data bit 3 equals (tx_level <= 96) AND tx_en, as sampled at the previous edge. dma_tx_req always equals rd_data bit 3.
- R7: rd_data bit 4 equals rx_trig AND rx_en, as sampled at the previous edge. dma_rx_req always equals rd_data bit 4.
- R8: rd_data bit 0 equals rx_end_err as sampled at the previous edge.
- R9: Writes to bits 4, 3 and 0 have no effect. Those bits follow only their hardware conditions.
- R10: irq equals bit5 | bit2 | bit1 | bit0 | (bit3 & tx_irq_en) | (bit4 & rx_irq_en). The status bits are the ones visible in the same cycle, and the enables are the ones sampled at the previous edge. irq falls in the same cycle as the last source bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | 8 | Transmit FIFO occupancy in entries |
| tx_en | input | 1 | Transmitter enable |
| rx_trig | input | 1 | Receive FIFO has reached its trigger level |
| rx_en | input | 1 | Receiver enable |
| rx_end_err | input | 1 | End or error entry present in receive FIFO |
| tx_irq_en | input | 1 | Interrupt enable for transmit service flag |
| rx_irq_en | input | 1 | Interrupt enable for receive service flag |
| frame_err_pulse | input | 1 | One-cycle framing error event |
| rx_abort_pulse | input | 1 | One-cycle receiver abort event |
| tx_underrun_pulse | input | 1 | One-cycle transmit underrun event |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 6 | Write data; a 1 clears the matching sticky bit |
| rd_data | output | 32 | Register read value |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| irq | output | 1 | Combined interrupt request |

## Verification
A sticky bit stuck in the wrong state shows in rd_data one edge after the pulse or write that should have moved it. If the set-over-clear priority is reversed, an event is lost in exactly the cycle where both arrive. An off-by-one threshold compare shows only at occupancy 96 or 97, so the bench sweeps every level with the transmitter both on and off. An interrupt combiner that reads stale state lags rd_data by one cycle, and that lag is visible on any clear.

// File: rtl/irda_stat_pkg.sv
package irda_stat_pkg;
  localparam int STAT_W   = 6;
  localparam int BUS_W    = 32;
  localparam int B_EOE    = 0;
  localparam int B_TXUR   = 1;
  localparam int B_RXAB   = 2;
  localparam int B_TXSVC  = 3;
  localparam int B_RXSVC  = 4;
  localparam int B_FRERR  = 5;
  localparam int N_STICKY = 3;
  // sticky bit positions, in generate order
  localparam int STICKY_POS [N_STICKY] = '{B_FRERR, B_RXAB, B_TXUR};
endpackage

// File: rtl/stat_sticky.sv
module stat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic q,
  output logic q_nxt
);
  always_comb begin
    q_nxt = q;
    if (clr_req) q_nxt = 1'b0;
    if (set_evt) q_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> q);
  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !q);
endmodule

// File: rtl/stat_svc_flags.sv
module stat_svc_flags #(
  parameter int FIFO_DEPTH = 128,
  parameter int TX_THRESH  = 96,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_en,
  input  logic             rx_trig,
  input  logic             rx_en,
  input  logic             rx_end_err,
  output logic             tx_flag,
  output logic             rx_flag,
  output logic             eoe_flag,
  output logic             tx_flag_nxt,
  output logic             rx_flag_nxt,
  output logic             eoe_flag_nxt
);
  localparam logic [LVL_W-1:0] THR_V = LVL_W'(TX_THRESH);

  always_comb begin
    tx_flag_nxt  = tx_en && (tx_level <= THR_V);
    rx_flag_nxt  = rx_en && rx_trig;
    eoe_flag_nxt = rx_end_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_flag  <= 1'b0;
      rx_flag  <= 1'b0;
      eoe_flag <= 1'b0;
    end else begin
      tx_flag  <= tx_flag_nxt;
      rx_flag  <= rx_flag_nxt;
      eoe_flag <= eoe_flag_nxt;
    end
  end

  // R6
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_flag);
  // R7
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_flag);
endmodule

// File: rtl/stat_irq_comb.sv
module stat_irq_comb
  import irda_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_nxt,
  input  logic              tx_irq_en,
  input  logic              rx_irq_en,
  output logic              irq
);
  logic irq_nxt;

  always_comb begin
    irq_nxt = stat_nxt[B_FRERR] | stat_nxt[B_RXAB] | stat_nxt[B_TXUR] |
              stat_nxt[B_EOE]   |
              (stat_nxt[B_TXSVC] & tx_irq_en) |
              (stat_nxt[B_RXSVC] & rx_irq_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_nxt;
  end
endmodule

// File: rtl/irda_fifo_status.sv
module irda_fifo_status
  import irda_stat_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int TX_THRESH  = 96,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic              tx_en,
  input  logic              rx_trig,
  input  logic              rx_en,
  input  logic              rx_end_err,
  input  logic              tx_irq_en,
  input  logic              rx_irq_en,
  input  logic              frame_err_pulse,
  input  logic              rx_abort_pulse,
  input  logic              tx_underrun_pulse,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [BUS_W-1:0]  rd_data,
  output logic              dma_tx_req,
  output logic              dma_rx_req,
  output logic              irq
);
  logic [STAT_W-1:0]   stat_q;
  logic [STAT_W-1:0]   stat_nxt;
  logic [N_STICKY-1:0] evt_vec;

  assign evt_vec = {tx_underrun_pulse, rx_abort_pulse, frame_err_pulse};

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    stat_sticky i_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (evt_vec[g]),
      .clr_req (wr_en && wr_data[STICKY_POS[g]]),
      .q       (stat_q[STICKY_POS[g]]),
      .q_nxt   (stat_nxt[STICKY_POS[g]])
    );
  end

  stat_svc_flags #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .TX_THRESH  (TX_THRESH)
  ) i_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_level     (tx_level),
    .tx_en        (tx_en),
    .rx_trig      (rx_trig),
    .rx_en        (rx_en),
    .rx_end_err   (rx_end_err),
    .tx_flag      (stat_q[B_TXSVC]),
    .rx_flag      (stat_q[B_RXSVC]),
    .eoe_flag     (stat_q[B_EOE]),
    .tx_flag_nxt  (stat_nxt[B_TXSVC]),
    .rx_flag_nxt  (stat_nxt[B_RXSVC]),
    .eoe_flag_nxt (stat_nxt[B_EOE])
  );

  stat_irq_comb i_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_nxt  (stat_nxt),
    .tx_irq_en (tx_irq_en),
    .rx_irq_en (rx_irq_en),
    .irq       (irq)
  );

  assign rd_data    = {{(BUS_W-STAT_W){1'b0}}, stat_q};
  assign dma_tx_req = stat_q[B_TXSVC];
  assign dma_rx_req = stat_q[B_RXSVC];

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> !irq);
  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[B_FRERR] | stat_q[B_RXAB] | stat_q[B_TXUR] | stat_q[B_EOE]) |-> irq);
  // R9
  ro_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rx_end_err) |=> !stat_q[B_EOE]);
endmodule

// File: tb/test_irda_fifo_status.sv
module test_irda_fifo_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tx_level = '0;
  logic        tx_en = 0, rx_trig = 0, rx_en = 0, rx_end_err = 0;
  logic        tx_irq_en = 0, rx_irq_en = 0;
  logic        fe_p = 0, ab_p = 0, ur_p = 0, wr_en = 0;
  logic [5:0]  wr_data = '0;
  logic [31:0] rd_data;
  logic        dma_tx_req, dma_rx_req, irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0] m_stat = '0;
  logic       m_irq = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  irda_fifo_status i_irda_fifo_status (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .tx_en(tx_en),
    .rx_trig(rx_trig), .rx_en(rx_en), .rx_end_err(rx_end_err),
    .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
    .frame_err_pulse(fe_p), .rx_abort_pulse(ab_p), .tx_underrun_pulse(ur_p),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compute model from inputs currently driven, clock once, compare
  task automatic step();
    logic [5:0] nx;
    nx = m_stat;
    if (wr_en) nx[5] = nx[5] & ~wr_data[5];
    if (wr_en) nx[2] = nx[2] & ~wr_data[2];
    if (wr_en) nx[1] = nx[1] & ~wr_data[1];
    if (fe_p) nx[5] = 1'b1;
    if (ab_p) nx[2] = 1'b1;
    if (ur_p) nx[1] = 1'b1;
    nx[3] = tx_en && (int'(tx_level) <= 96);
    nx[4] = rx_en && rx_trig;
    nx[0] = rx_end_err;
    m_irq = nx[5] | nx[2] | nx[1] | nx[0] | (nx[3] & tx_irq_en) | (nx[4] & rx_irq_en);
    m_stat = nx;
    @(posedge clk);
    #2;
    chk("R2 upper bits", {6'd0, rd_data[31:6]}, 32'd0);
    chk("R3/R4/R5 sticky", {29'd0, rd_data[5], rd_data[2], rd_data[1]},
        {29'd0, m_stat[5], m_stat[2], m_stat[1]});
    chk("R6 tx flag", {30'd0, rd_data[3], dma_tx_req}, {30'd0, m_stat[3], m_stat[3]});
    chk("R7 rx flag", {30'd0, rd_data[4], dma_rx_req}, {30'd0, m_stat[4], m_stat[4]});
    chk("R8 R9 eoe flag", {31'd0, rd_data[0]}, {31'd0, m_stat[0]});
    chk("R10 irq", {31'd0, irq}, {31'd0, m_irq});
    @(negedge clk);
  endtask

  task automatic idle();
    fe_p = 0; ab_p = 0; ur_p = 0; wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3;
    chk("R1 reset rd_data", rd_data, 32'd0);
    chk("R1 reset outputs", {29'd0, dma_tx_req, dma_rx_req, irq}, 32'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 sweep every level with transmitter on and off
    for (int e = 0; e < 2; e++) begin
      for (int l = 0; l <= 128; l++) begin
        tx_en = e[0]; tx_level = 8'(l); tx_irq_en = l[0];
        step();
      end
    end
    tx_en = 0;
    // R7 all rx combinations
    for (int c = 0; c < 8; c++) begin
      rx_trig = c[0]; rx_en = c[1]; rx_irq_en = c[2];
      step();
    end
    rx_en = 0; rx_trig = 0;
    // R3 set each sticky, R4 write 0 keeps, R4 write 1 clears, R10 irq drop
    fe_p = 1; ab_p = 1; ur_p = 1; step(); idle();
    wr_en = 1; wr_data = 6'b011001; step(); idle();
    wr_en = 1; wr_data = 6'b100000; step(); idle();
    wr_en = 1; wr_data = 6'b000110; step(); idle();
    step();
    // R5 set and clear together
    wr_en = 1; wr_data = 6'b111111; fe_p = 1; ab_p = 1; ur_p = 1; step(); idle();
    wr_en = 1; wr_data = 6'b100110; step(); idle();
    // R9 writes to read-only bits while conditions high and low
    rx_end_err = 1; tx_en = 1; tx_level = 8'd10; rx_en = 1; rx_trig = 1;
    wr_en = 1; wr_data = 6'b011001; step(); step(); idle();
    rx_end_err = 0; tx_en = 0; rx_en = 0;
    wr_en = 1; wr_data = 6'b011001; step(); idle();
    // mixed pseudo-random stimulus
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_level = 8'(90 + (lfsr[4:0] % 12));
      tx_en = lfsr[5]; rx_trig = lfsr[6]; rx_en = lfsr[7]; rx_end_err = lfsr[8] & lfsr[9];
      tx_irq_en = lfsr[10]; rx_irq_en = lfsr[11];
      fe_p = lfsr[12] & lfsr[2]; ab_p = lfsr[13] & lfsr[3]; ur_p = lfsr[14] & lfsr[1];
      wr_en = lfsr[15]; wr_data = {lfsr[0], lfsr[9:5]};
      step();
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule